// File: doc/BRIEF.md
# Programmable Header Bit Classifier

The classifier receives the leading 64 bits of a bus cell and turns them into a transmit-queue index. It builds two priority bits and four queue-group bits. Each of these six bits is copied from a header bit position chosen by its own 6-bit selector. The selected positions may be scattered across the header, may appear in any order, and may repeat. A mode input switches between four-bit and three-bit groups. With the mode low, the top group bit is held at zero and its selector has no effect.

Headers enter on a valid/ready stream, and queue indices leave on a valid/ready stream. The block holds one result register. It accepts a header when that register is empty, or when the downstream side takes the held result in the same cycle. It therefore sustains one header per cycle. When the downstream side stalls, `hdr_ready` drops, and the held index stays frozen until it is taken. The selectors and the mode bit are read only in the cycle a header is accepted. A later write affects only later headers.

Top module: `hdr_bit_classifier`

## Requirements
- R1: After reset, `q_valid` is 0 and `hdr_ready` is 1.
- R2: A selector value p picks header bit `hdr_data[63-p]`. Value 0 picks the most significant bit, and value 63 picks bit 0.
- R3: The index is `q_index = {g3, g2, g1, g0, p1, p0}`. Bits [1:0] carry the priority, and bits [5:2] carry the group. Selector fields are `pri_sel = {p1_sel[11:6], p0_sel[5:0]}` and `grp_sel = {g3_sel[23:18], g2_sel[17:12], g1_sel[11:6], g0_sel[5:0]}`.
- R4: Each of the six selectors acts on its own. Positions may be non-adjacent, in any order, or equal to one another.
- R5: When `ext_mode` is 0 at acceptance, `q_index[5]` is 0 whatever `grp_sel[23:18]` and the header contain.
- R6: A header is accepted on a rising edge where `hdr_valid` and `hdr_ready` are both 1. After that edge, `q_valid` is 1 and `q_index` holds the index of that header.
- R7: While `q_valid` is 1 and `q_ready` is 0, `hdr_ready` is 0, no header is accepted, and `q_index` stays unchanged.
- R8: Selector and mode changes made after a header is accepted do not alter that header's index. The index uses the values present in the accept cycle.
- R9: With `hdr_valid` and `q_ready` held at 1, a new header is accepted every cycle. Each index appears one cycle after its header, in order.
- R10: When the held index is taken and no header is accepted in the same cycle, `q_valid` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header word present |
| hdr_ready | output | 1 | Block can take a header this cycle |
| hdr_data | input | 64 | First 64 header bits; bit 63 is position 0 |
| pri_sel | input | 12 | Two 6-bit priority bit selectors |
| grp_sel | input | 24 | Four 6-bit group bit selectors |
| ext_mode | input | 1 | 1: four group bits; 0: top group bit forced to 0 |
| q_valid | output | 1 | Queue index present |
| q_ready | input | 1 | Downstream takes the index |
| q_index | output | 6 | Destination queue {group, priority} |

## Verification
Handing off the held index and accepting a new header can occur on the same edge. The bench provokes this in two ways. First, it releases a stall while a second header is already waiting with different selectors. Second, it streams headers back to back with `q_ready` held high. The bench then checks that the first index is kept until release and that the next index follows on the very next cycle. It also checks that this next index reflects the selectors that were present at its own acceptance.

// File: rtl/hdr_cls_pkg.sv
package hdr_cls_pkg;
  localparam int unsigned HDR_W_DEF = 64;
  localparam int unsigned PRI_BITS_DEF = 2;
  localparam int unsigned GRP_BITS_DEF = 4;
endpackage

// File: rtl/hdr_bit_pick.sv
module hdr_bit_pick #(
  parameter int unsigned HDR_W = 64,
  parameter int unsigned SEL_W = $clog2(HDR_W)
) (
  input  logic [HDR_W-1:0] hdr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             bit_o
);
  // position 0 is the first bit on the bus, i.e. the MSB
  logic [HDR_W-1:0] by_pos;

  for (genvar i = 0; i < HDR_W; i++) begin : g_rev
    assign by_pos[i] = hdr_i[HDR_W-1-i];
  end

  assign bit_o = by_pos[sel_i];
endmodule

// File: rtl/hdr_cls_core.sv
module hdr_cls_core #(
  parameter int unsigned HDR_W = 64,
  parameter int unsigned PRI_BITS = 2,
  parameter int unsigned GRP_BITS = 4,
  localparam int unsigned SEL_W = $clog2(HDR_W),
  localparam int unsigned IDX_W = PRI_BITS + GRP_BITS
) (
  input  logic [HDR_W-1:0]          hdr_i,
  input  logic [PRI_BITS*SEL_W-1:0] pri_sel_i,
  input  logic [GRP_BITS*SEL_W-1:0] grp_sel_i,
  input  logic                      ext_mode_i,
  output logic [IDX_W-1:0]          idx_o
);
  logic [PRI_BITS-1:0] pri_bits;
  logic [GRP_BITS-1:0] grp_raw;
  logic [GRP_BITS-1:0] grp_bits;

  for (genvar p = 0; p < PRI_BITS; p++) begin : g_pri
    hdr_bit_pick #(.HDR_W(HDR_W), .SEL_W(SEL_W)) u_pick (
      .hdr_i (hdr_i),
      .sel_i (pri_sel_i[p*SEL_W +: SEL_W]),
      .bit_o (pri_bits[p])
    );
  end

  for (genvar g = 0; g < GRP_BITS; g++) begin : g_grp
    hdr_bit_pick #(.HDR_W(HDR_W), .SEL_W(SEL_W)) u_pick (
      .hdr_i (hdr_i),
      .sel_i (grp_sel_i[g*SEL_W +: SEL_W]),
      .bit_o (grp_raw[g])
    );
    if (g == GRP_BITS-1) begin : g_top
      // top group bit only exists in extended mode
      assign grp_bits[g] = grp_raw[g] & ext_mode_i;
    end else begin : g_low
      assign grp_bits[g] = grp_raw[g];
    end
  end

  assign idx_o = {grp_bits, pri_bits};
endmodule

// File: rtl/hdr_cls_out_stage.sv
module hdr_cls_out_stage #(
  parameter int unsigned DATA_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;
  logic              take;

  assign in_ready = !full_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
    end else if (take) begin
      full_q <= 1'b1;
    end else if (out_ready) begin
      full_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (take) begin
      data_q <= in_data;
    end
  end

  assign out_valid = full_q;
  assign out_data  = data_q;
endmodule

// File: rtl/hdr_bit_classifier.sv
module hdr_bit_classifier
  import hdr_cls_pkg::*;
#(
  parameter int unsigned HDR_W = HDR_W_DEF,
  parameter int unsigned PRI_BITS = PRI_BITS_DEF,
  parameter int unsigned GRP_BITS = GRP_BITS_DEF,
  localparam int unsigned SEL_W = $clog2(HDR_W),
  localparam int unsigned IDX_W = PRI_BITS + GRP_BITS
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      hdr_valid,
  output logic                      hdr_ready,
  input  logic [HDR_W-1:0]          hdr_data,
  input  logic [PRI_BITS*SEL_W-1:0] pri_sel,
  input  logic [GRP_BITS*SEL_W-1:0] grp_sel,
  input  logic                      ext_mode,
  output logic                      q_valid,
  input  logic                      q_ready,
  output logic [IDX_W-1:0]          q_index
);
  logic [IDX_W-1:0] idx_comb;

  hdr_cls_core #(
    .HDR_W(HDR_W), .PRI_BITS(PRI_BITS), .GRP_BITS(GRP_BITS)
  ) u_core (
    .hdr_i      (hdr_data),
    .pri_sel_i  (pri_sel),
    .grp_sel_i  (grp_sel),
    .ext_mode_i (ext_mode),
    .idx_o      (idx_comb)
  );

  hdr_cls_out_stage #(.DATA_W(IDX_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (hdr_valid),
    .in_ready  (hdr_ready),
    .in_data   (idx_comb),
    .out_valid (q_valid),
    .out_ready (q_ready),
    .out_data  (q_index)
  );
endmodule

// File: rtl/hdr_bit_classifier_chk.sv
module hdr_bit_classifier_chk #(
  parameter int unsigned IDX_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hdr_valid,
  input logic             hdr_ready,
  input logic             ext_mode,
  input logic             q_valid,
  input logic             q_ready,
  input logic [IDX_W-1:0] q_index
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) $rose(rst_n) |-> !q_valid && hdr_ready);

  // R5
  short_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready && !ext_mode) |=> !q_index[IDX_W-1]);

  // R6
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_valid && hdr_ready) |=> q_valid);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |=> q_valid && $stable(q_index));

  // R7
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !q_ready) |-> !hdr_ready);

  // R10
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && q_ready && !hdr_valid) |=> !q_valid);
endmodule

bind hdr_bit_classifier hdr_bit_classifier_chk #(.IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hdr_valid (hdr_valid),
  .hdr_ready (hdr_ready),
  .ext_mode  (ext_mode),
  .q_valid   (q_valid),
  .q_ready   (q_ready),
  .q_index   (q_index)
);

// File: tb/tb_hdr_bit_classifier.sv
module tb_hdr_bit_classifier;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_valid = 1'b0;
  logic        hdr_ready;
  logic [63:0] hdr_data = '0;
  logic [11:0] pri_sel = '0;
  logic [23:0] grp_sel = '0;
  logic        ext_mode = 1'b1;
  logic        q_valid;
  logic        q_ready = 1'b1;
  logic [5:0]  q_index;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hdr_bit_classifier dut (
    .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .hdr_ready(hdr_ready),
    .hdr_data(hdr_data), .pri_sel(pri_sel), .grp_sel(grp_sel),
    .ext_mode(ext_mode), .q_valid(q_valid), .q_ready(q_ready),
    .q_index(q_index)
  );

  // {hdr[64], sel{g3,g2,g1,g0,p1,p0}[36], ext[1]}
  localparam logic [100:0] VECS [8] = '{
    {64'h8000000000000000, 36'h0, 1'b1},
    {64'h8000000000000000, 36'h0, 1'b0},
    {64'h0000000000000001, 36'hFFFFFFFFF, 1'b1},
    {64'hA5A5A5A5A5A5A5A5, 6'd7, 6'd1, 6'd62, 6'd0, 6'd33, 6'd2, 1'b1},
    {64'h0000000000000000, 36'hFFFFFFFFF, 1'b1},
    {64'hFFFFFFFFFFFFFFFF, 6'd5, 6'd5, 6'd5, 6'd5, 6'd5, 6'd5, 1'b0},
    {64'h0123456789ABCDEF, 6'd5, 6'd4, 6'd3, 6'd2, 6'd1, 6'd0, 1'b1},
    {64'hFEDCBA9876543210, 6'd60, 6'd9, 6'd31, 6'd47, 6'd12, 6'd63, 1'b1}
  };

  // expected index from the requirements: position p is the p-th bit from the MSB
  function automatic logic [5:0] ref_idx(logic [63:0] h, logic [35:0] s, logic ext);
    logic [5:0]  r;
    logic [63:0] t;
    for (int i = 0; i < 6; i++) begin
      t = h << s[i*6 +: 6];
      r[i] = t[63];
    end
    if (!ext) r[5] = 1'b0;
    return r;
  endfunction

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(logic [63:0] h, logic [35:0] s, logic ext);
    hdr_data = h;
    pri_sel  = s[11:0];
    grp_sel  = s[35:12];
    ext_mode = ext;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [5:0]  exp_a;
    logic [5:0]  exp_b;
    logic [35:0] s_a;
    logic [35:0] s_b;
    logic [5:0]  exp_q [4];

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 q_valid", {5'd0, q_valid}, 6'd0);
    chk("R1 hdr_ready", {5'd0, hdr_ready}, 6'd1);

    // vector table: R2, R3, R4, R5, R6, R10
    for (int k = 0; k < 8; k++) begin
      drive(VECS[k][100:37], VECS[k][36:1], VECS[k][0]);
      hdr_valid = 1'b1;
      q_ready = 1'b1;
      @(negedge clk);
      hdr_valid = 1'b0;
      chk("R6 valid after accept", {5'd0, q_valid}, 6'd1);
      chk("R2 R3 R4 R5 index", q_index,
          ref_idx(VECS[k][100:37], VECS[k][36:1], VECS[k][0]));
      @(negedge clk);
      chk("R10 drained", {5'd0, q_valid}, 6'd0);
    end

    // R5: top group selector points at a 1 bit, mode low
    drive(64'h4000000000000000, {6'd1, 6'd2, 6'd2, 6'd2, 6'd2, 6'd2}, 1'b0);
    hdr_valid = 1'b1;
    @(negedge clk);
    hdr_valid = 1'b0;
    chk("R5 top group bit forced", q_index, 6'h00);
    @(negedge clk);

    // R7 R8: stall, then concurrent handoff and accept
    s_a = {6'd0, 6'd8, 6'd16, 6'd24, 6'd32, 6'd40};
    s_b = {6'd63, 6'd62, 6'd61, 6'd60, 6'd59, 6'd58};
    exp_a = ref_idx(64'h80808080FFFF0000, s_a, 1'b1);
    exp_b = ref_idx(64'h000000000000003F, s_b, 1'b1);
    q_ready = 1'b0;
    drive(64'h80808080FFFF0000, s_a, 1'b1);
    hdr_valid = 1'b1;
    @(negedge clk);
    chk("R6 first held", q_index, exp_a);
    drive(64'h000000000000003F, s_b, 1'b1);
    for (int c = 0; c < 3; c++) begin
      chk("R7 ready low in stall", {5'd0, hdr_ready}, 6'd0);
      @(negedge clk);
      chk("R7 R8 index held", q_index, exp_a);
      chk("R7 still valid", {5'd0, q_valid}, 6'd1);
    end
    q_ready = 1'b1;
    @(negedge clk);
    chk("R9 handoff and accept same edge", q_index, exp_b);
    chk("R9 valid after overlap", {5'd0, q_valid}, 6'd1);
    hdr_valid = 1'b0;
    // R8: selectors change after acceptance, held output unaffected
    q_ready = 1'b0;
    drive(64'h0, 36'h0, 1'b0);
    @(negedge clk);
    chk("R8 later writes ignored", q_index, exp_b);
    q_ready = 1'b1;
    @(negedge clk);
    chk("R10 empty after take", {5'd0, q_valid}, 6'd0);

    // R9: back-to-back stream
    for (int k = 0; k < 4; k++) begin
      drive(VECS[k+3][100:37], VECS[k+3][36:1], VECS[k+3][0]);
      exp_q[k] = ref_idx(VECS[k+3][100:37], VECS[k+3][36:1], VECS[k+3][0]);
      hdr_valid = 1'b1;
      @(negedge clk);
      chk("R9 stream index", q_index, exp_q[k]);
      chk("R9 stream ready", {5'd0, hdr_ready}, 6'd1);
    end
    hdr_valid = 1'b0;
    @(negedge clk);
    chk("R10 stream drained", {5'd0, q_valid}, 6'd0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule